// File: doc/BRIEF.md
# Pipeline Hazard and Operand Forwarding Control

This block is the purely combinational hazard controller for a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback). Branch prediction is absent. It looks at register indices in decode and execute. It also looks at the destination indices and write enables of the instructions in the memory and writeback stages. From these it picks where each execute-stage operand comes from: the register file, the memory-stage result, or the writeback-stage result.

It also watches the instruction in execute. If that instruction is a load and the instruction in decode needs its result, the block freezes the program counter and the fetch/decode register for one cycle and sends a bubble into execute. Branches and jumps are resolved in execute and nothing is speculated. So when execute reports a taken transfer, the block discards both younger instructions. It clears the fetch/decode register and turns the instruction leaving decode into a bubble.

The pipeline registers and the datapath sit outside this block. They apply the strobes on the next clock edge.

Top module: `hazardFwdCtrl`

## Requirements
- R1: When the memory-stage instruction writes a nonzero destination equal to an execute source index, that operand's select is 2'b01 (memory-stage result).
- R2: When only the writeback-stage instruction writes a nonzero destination equal to an execute source index, that operand's select is 2'b10 (writeback-stage result).
- R3: When both the memory-stage and the writeback-stage destinations match the same source and both qualify, the select is 2'b01: the younger result wins.
- R4: A destination index of 0 is never forwarded, whatever its write enable.
- R5: A producer whose write enable is low is never forwarded, even when its index matches.
- R6: With no qualifying match, the select is 2'b00 (register file). The two operand selects are decided independently of each other.
- R7: A load in execute with a nonzero destination matching either decode source, with no taken transfer, raises holdPc, holdIfId and bubbleEx and leaves flushIfId low.
- R8: The load-use stall lasts exactly one cycle. Once the bubble has replaced the load in execute (memory-read flag low), all hold and bubble outputs drop.
- R9: A non-load in execute, or a load whose destination is 0, causes no stall, even when the indices match.
- R10: A taken branch or jump raises flushIfId and bubbleEx and leaves both holds low.
- R11: A taken transfer overrides a coincident load-use hazard: the holds stay low, and flushIfId and bubbleEx are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| idRs1 | input | REG_ADDR_W | First source index of the instruction in decode |
| idRs2 | input | REG_ADDR_W | Second source index of the instruction in decode |
| exRs1 | input | REG_ADDR_W | First source index of the instruction in execute |
| exRs2 | input | REG_ADDR_W | Second source index of the instruction in execute |
| exRd | input | REG_ADDR_W | Destination index of the instruction in execute |
| exMemRead | input | 1 | Instruction in execute is a load |
| exTaken | input | 1 | Branch or jump in execute is taken |
| memRd | input | REG_ADDR_W | Destination index in the execute/memory register |
| memRegWrite | input | 1 | Memory-stage instruction writes a register |
| wbRd | input | REG_ADDR_W | Destination index in the memory/writeback register |
| wbRegWrite | input | 1 | Writeback-stage instruction writes a register |
| fwdSelA | output | 2 | First operand source: 00 register file, 01 memory stage, 10 writeback stage |
| fwdSelB | output | 2 | Second operand source, same encoding |
| holdPc | output | 1 | Keep the program counter unchanged |
| holdIfId | output | 1 | Keep the fetch/decode register unchanged |
| bubbleEx | output | 1 | Load a bubble into the decode/execute register |
| flushIfId | output | 1 | Clear the fetch/decode register |

## Verification
The bench builds two copies. The first uses the default 5-bit register index. It runs directed scenarios on realistic indices, including register 31 and indices that differ only in their top bit. The second is built with a 3-bit index. That space is small enough to sweep every combination of first source, memory-stage destination, writeback-stage destination and both write enables against a model derived from the requirements. This reaches all priority and zero-register corners exhaustively.

// File: rtl/hzPkg.sv
package hzPkg;

  typedef enum logic [1:0] {
    FWD_NONE  = 2'b00,
    FWD_EXMEM = 2'b01,
    FWD_MEMWB = 2'b10
  } fwdSel_e;

  // Strobes from the stall/flush control to the top-level outputs
  typedef struct packed {
    logic holdFront;   // freeze PC and fetch/decode register
    logic squashId;    // replace the instruction entering execute with a bubble
    logic flushFetch;  // clear the fetch/decode register
  } hzStrobe_t;

endpackage

// File: rtl/hzFwdPath.sv
module hzFwdPath
  import hzPkg::*;
#(
  parameter int REG_ADDR_W = 5,
  parameter int NUM_EX_SRC = 2
) (
  input  logic [NUM_EX_SRC-1:0][REG_ADDR_W-1:0] exSrc,
  input  logic [REG_ADDR_W-1:0]                 memRd,
  input  logic                                  memRegWrite,
  input  logic [REG_ADDR_W-1:0]                 wbRd,
  input  logic                                  wbRegWrite,
  output logic [NUM_EX_SRC-1:0][1:0]            srcSel
);

  localparam logic [REG_ADDR_W-1:0] ZERO_REG = '0;

  logic memLive;
  logic wbLive;

  // A producer qualifies only if it writes and its target is not the zero register
  assign memLive = memRegWrite && (memRd != ZERO_REG);
  assign wbLive  = wbRegWrite  && (wbRd  != ZERO_REG);

  for (genvar i = 0; i < NUM_EX_SRC; i++) begin : g_src
    logic    memHit;
    logic    wbHit;
    fwdSel_e pick;

    assign memHit = memLive && (memRd == exSrc[i]);
    assign wbHit  = wbLive  && (wbRd  == exSrc[i]);

    always_comb begin
      if (memHit)     pick = FWD_EXMEM;   // younger result has priority
      else if (wbHit) pick = FWD_MEMWB;
      else            pick = FWD_NONE;
    end

    assign srcSel[i] = pick;
  end

endmodule

// File: rtl/hzStallCtrl.sv
module hzStallCtrl
  import hzPkg::*;
#(
  parameter int REG_ADDR_W = 5,
  parameter int NUM_ID_SRC = 2
) (
  input  logic [NUM_ID_SRC-1:0][REG_ADDR_W-1:0] idSrc,
  input  logic [REG_ADDR_W-1:0]                 exRd,
  input  logic                                  exMemRead,
  input  logic                                  exTaken,
  output hzStrobe_t                             strobe
);

  localparam logic [REG_ADDR_W-1:0] ZERO_REG = '0;

  logic [NUM_ID_SRC-1:0] useHit;
  logic                  loadUse;

  for (genvar i = 0; i < NUM_ID_SRC; i++) begin : g_use
    assign useHit[i] = (exRd == idSrc[i]);
  end

  assign loadUse = exMemRead && (exRd != ZERO_REG) && (|useHit);

  always_comb begin
    strobe            = '0;
    strobe.flushFetch = exTaken;
    // A taken transfer discards the decode instruction, so a hold is pointless
    strobe.holdFront  = loadUse && !exTaken;
    strobe.squashId   = loadUse || exTaken;
  end

endmodule

// File: rtl/hazardFwdCtrl.sv
module hazardFwdCtrl
  import hzPkg::*;
#(
  parameter int REG_ADDR_W = 5
) (
  input  logic [REG_ADDR_W-1:0] idRs1,
  input  logic [REG_ADDR_W-1:0] idRs2,
  input  logic [REG_ADDR_W-1:0] exRs1,
  input  logic [REG_ADDR_W-1:0] exRs2,
  input  logic [REG_ADDR_W-1:0] exRd,
  input  logic                  exMemRead,
  input  logic                  exTaken,
  input  logic [REG_ADDR_W-1:0] memRd,
  input  logic                  memRegWrite,
  input  logic [REG_ADDR_W-1:0] wbRd,
  input  logic                  wbRegWrite,
  output logic [1:0]            fwdSelA,
  output logic [1:0]            fwdSelB,
  output logic                  holdPc,
  output logic                  holdIfId,
  output logic                  bubbleEx,
  output logic                  flushIfId
);

  localparam int NUM_SRC = 2;

  logic [NUM_SRC-1:0][REG_ADDR_W-1:0] exSrcBus;
  logic [NUM_SRC-1:0][REG_ADDR_W-1:0] idSrcBus;
  logic [NUM_SRC-1:0][1:0]            selBus;
  hzStrobe_t                          strobe;

  assign exSrcBus = {exRs2, exRs1};
  assign idSrcBus = {idRs2, idRs1};

  hzFwdPath #(
    .REG_ADDR_W (REG_ADDR_W),
    .NUM_EX_SRC (NUM_SRC)
  ) u_fwd (
    .exSrc       (exSrcBus),
    .memRd       (memRd),
    .memRegWrite (memRegWrite),
    .wbRd        (wbRd),
    .wbRegWrite  (wbRegWrite),
    .srcSel      (selBus)
  );

  hzStallCtrl #(
    .REG_ADDR_W (REG_ADDR_W),
    .NUM_ID_SRC (NUM_SRC)
  ) u_ctrl (
    .idSrc     (idSrcBus),
    .exRd      (exRd),
    .exMemRead (exMemRead),
    .exTaken   (exTaken),
    .strobe    (strobe)
  );

  assign fwdSelA   = selBus[0];
  assign fwdSelB   = selBus[1];
  assign holdPc    = strobe.holdFront;
  assign holdIfId  = strobe.holdFront;
  assign bubbleEx  = strobe.squashId;
  assign flushIfId = strobe.flushFetch;

endmodule

// File: rtl/hazardFwdCtrlChk.sv
module hazardFwdCtrlChk #(
  parameter int REG_ADDR_W = 5
) (
  input logic [REG_ADDR_W-1:0] idRs1,
  input logic [REG_ADDR_W-1:0] idRs2,
  input logic [REG_ADDR_W-1:0] exRs1,
  input logic [REG_ADDR_W-1:0] exRd,
  input logic                  exMemRead,
  input logic                  exTaken,
  input logic [REG_ADDR_W-1:0] memRd,
  input logic                  memRegWrite,
  input logic [REG_ADDR_W-1:0] wbRd,
  input logic                  wbRegWrite,
  input logic [1:0]            fwdSelA,
  input logic [1:0]            fwdSelB,
  input logic                  holdPc,
  input logic                  holdIfId,
  input logic                  bubbleEx,
  input logic                  flushIfId
);

  localparam logic [REG_ADDR_W-1:0] ZERO_REG = '0;

  always_comb begin
    a_r1_mem_first: assert (!(memRegWrite && memRd != ZERO_REG && memRd == exRs1)
                            || fwdSelA == 2'b01);
    a_r4_zero_never: assert (!(memRd == ZERO_REG && wbRd == ZERO_REG && exRs1 == ZERO_REG)
                             || fwdSelA == 2'b00);
    a_r6_sel_legal: assert (fwdSelA != 2'b11 && fwdSelB != 2'b11);
    a_r7_holds_pair: assert (holdPc == holdIfId);
    a_r7_hold_bubbles: assert (!holdPc || bubbleEx);
    a_r9_no_load_no_hold: assert (exMemRead || !holdPc);
    a_r10_flush_bubbles: assert (!exTaken || (flushIfId && bubbleEx && !holdPc));
    a_r11_flush_only_taken: assert (exTaken || !flushIfId);
    a_r7_stall_seen: assert (!(exMemRead && !exTaken && exRd != ZERO_REG
                               && (exRd == idRs1 || exRd == idRs2)) || holdPc);
    a_r5_wen_gates: assert (memRegWrite || wbRegWrite || fwdSelA == 2'b00);
  end

endmodule

bind hazardFwdCtrl hazardFwdCtrlChk #(.REG_ADDR_W(REG_ADDR_W)) u_chk (
  .idRs1       (idRs1),
  .idRs2       (idRs2),
  .exRs1       (exRs1),
  .exRd        (exRd),
  .exMemRead   (exMemRead),
  .exTaken     (exTaken),
  .memRd       (memRd),
  .memRegWrite (memRegWrite),
  .wbRd        (wbRd),
  .wbRegWrite  (wbRegWrite),
  .fwdSelA     (fwdSelA),
  .fwdSelB     (fwdSelB),
  .holdPc      (holdPc),
  .holdIfId    (holdIfId),
  .bubbleEx    (bubbleEx),
  .flushIfId   (flushIfId)
);

// File: tb/hazardFwdCtrl_tb.sv
module hazardFwdCtrl_tb;

  localparam int W  = 5;
  localparam int WS = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [W-1:0] idRs1, idRs2, exRs1, exRs2, exRd, memRd, wbRd;
  logic exMemRead, exTaken, memRegWrite, wbRegWrite;
  logic [1:0] fwdSelA, fwdSelB;
  logic holdPc, holdIfId, bubbleEx, flushIfId;

  hazardFwdCtrl #(.REG_ADDR_W(W)) u_dut (
    .idRs1(idRs1), .idRs2(idRs2), .exRs1(exRs1), .exRs2(exRs2), .exRd(exRd),
    .exMemRead(exMemRead), .exTaken(exTaken), .memRd(memRd), .memRegWrite(memRegWrite),
    .wbRd(wbRd), .wbRegWrite(wbRegWrite), .fwdSelA(fwdSelA), .fwdSelB(fwdSelB),
    .holdPc(holdPc), .holdIfId(holdIfId), .bubbleEx(bubbleEx), .flushIfId(flushIfId)
  );

  logic [WS-1:0] sExRs1, sMemRd, sWbRd;
  logic sMemWe, sWbWe;
  logic [1:0] sSelA, sSelB;
  logic sHoldPc, sHoldIfId, sBubble, sFlush;

  hazardFwdCtrl #(.REG_ADDR_W(WS)) u_small (
    .idRs1('0), .idRs2('0), .exRs1(sExRs1), .exRs2('0), .exRd('0),
    .exMemRead(1'b0), .exTaken(1'b0), .memRd(sMemRd), .memRegWrite(sMemWe),
    .wbRd(sWbRd), .wbRegWrite(sWbWe), .fwdSelA(sSelA), .fwdSelB(sSelB),
    .holdPc(sHoldPc), .holdIfId(sHoldIfId), .bubbleEx(sBubble), .flushIfId(sFlush)
  );

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // control outputs packed as {holdPc, holdIfId, bubbleEx, flushIfId}
  function automatic logic [3:0] ctl();
    return {holdPc, holdIfId, bubbleEx, flushIfId};
  endfunction

  task automatic idle();
    @(negedge clk);
    idRs1 = 5'd1; idRs2 = 5'd2; exRs1 = 5'd3; exRs2 = 5'd4; exRd = 5'd5;
    exMemRead = 0; exTaken = 0; memRd = 5'd6; memRegWrite = 1; wbRd = 5'd7; wbRegWrite = 1;
  endtask

  task automatic settle();
    #2;
  endtask

  task automatic t_idle();
    idle(); settle();
    chk("R6 idle selA", {2'b0, fwdSelA}, 4'h0);
    chk("R6 idle selB", {2'b0, fwdSelB}, 4'h0);
    chk("R9 idle ctl", ctl(), 4'h0);
  endtask

  task automatic t_memFwd();
    idle(); exRs1 = 5'd6; settle();
    chk("R1 mem fwd A", {2'b0, fwdSelA}, 4'h1);
    chk("R6 B independent", {2'b0, fwdSelB}, 4'h0);
    idle(); exRs2 = 5'd6; memRd = 5'd6; settle();
    chk("R1 mem fwd B", {2'b0, fwdSelB}, 4'h1);
  endtask

  task automatic t_wbFwd();
    idle(); exRs2 = 5'd7; settle();
    chk("R2 wb fwd B", {2'b0, fwdSelB}, 4'h2);
    chk("R6 A independent", {2'b0, fwdSelA}, 4'h0);
    idle(); exRs1 = 5'd6; exRs2 = 5'd7; settle();
    chk("R6 split A", {2'b0, fwdSelA}, 4'h1);
    chk("R6 split B", {2'b0, fwdSelB}, 4'h2);
  endtask

  task automatic t_priority();
    idle(); memRd = 5'd31; wbRd = 5'd31; exRs1 = 5'd31; exRs2 = 5'd31; settle();
    chk("R3 priority A", {2'b0, fwdSelA}, 4'h1);
    chk("R3 priority B", {2'b0, fwdSelB}, 4'h1);
    idle(); memRd = 5'd31; memRegWrite = 0; wbRd = 5'd31; exRs1 = 5'd31; settle();
    chk("R3 fallback to wb", {2'b0, fwdSelA}, 4'h2);
    idle(); memRd = 5'd17; exRs1 = 5'd1; settle();
    chk("R6 top-bit differ", {2'b0, fwdSelA}, 4'h0);
  endtask

  task automatic t_zeroAndWe();
    idle(); memRd = 0; wbRd = 0; exRs1 = 0; exRs2 = 0; settle();
    chk("R4 zero A", {2'b0, fwdSelA}, 4'h0);
    chk("R4 zero B", {2'b0, fwdSelB}, 4'h0);
    idle(); memRd = 0; exRs1 = 0; wbRd = 0; wbRegWrite = 0; settle();
    chk("R4 zero mem", {2'b0, fwdSelA}, 4'h0);
    idle(); memRegWrite = 0; wbRegWrite = 0; exRs1 = 5'd6; exRs2 = 5'd7; settle();
    chk("R5 no we A", {2'b0, fwdSelA}, 4'h0);
    chk("R5 no we B", {2'b0, fwdSelB}, 4'h0);
  endtask

  task automatic t_loadUse();
    idle(); exMemRead = 1; exRd = 5'd2; settle();
    chk("R7 load-use rs2", ctl(), 4'hE);
    idle(); exMemRead = 1; exRd = 5'd1; settle();
    chk("R7 load-use rs1", ctl(), 4'hE);
    // next cycle: bubble now in execute, load moved on to memory stage
    idle(); exRd = 0; memRd = 5'd1; exRs1 = 5'd1; settle();
    chk("R8 stall released", ctl(), 4'h0);
    chk("R8 load result forwarded", {2'b0, fwdSelA}, 4'h1);
  endtask

  task automatic t_noStall();
    idle(); exMemRead = 0; exRd = 5'd1; settle();
    chk("R9 non-load", ctl(), 4'h0);
    idle(); exMemRead = 1; exRd = 0; idRs1 = 0; settle();
    chk("R9 load to zero", ctl(), 4'h0);
    idle(); exMemRead = 1; exRd = 5'd9; settle();
    chk("R9 load no match", ctl(), 4'h0);
  endtask

  task automatic t_taken();
    idle(); exTaken = 1; settle();
    chk("R10 taken", ctl(), 4'h3);
    idle(); exTaken = 1; exMemRead = 1; exRd = 5'd1; settle();
    chk("R11 taken beats load-use", ctl(), 4'h3);
  endtask

  task automatic t_sweep();
    for (int s = 0; s < 8; s++)
      for (int m = 0; m < 8; m++)
        for (int w = 0; w < 8; w++)
          for (int e = 0; e < 4; e++) begin
            logic [1:0] exp;
            @(negedge clk);
            sExRs1 = WS'(s); sMemRd = WS'(m); sWbRd = WS'(w);
            sMemWe = e[0]; sWbWe = e[1];
            #2;
            if (e[0] && m != 0 && m == s)      exp = 2'b01;
            else if (e[1] && w != 0 && w == s) exp = 2'b10;
            else                               exp = 2'b00;
            chk("R3 sweep small", {2'b0, sSelA}, {2'b0, exp});
          end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    sExRs1 = 0; sMemRd = 0; sWbRd = 0; sMemWe = 0; sWbWe = 0;
    idle();
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    t_idle();
    t_memFwd();
    t_wbFwd();
    t_priority();
    t_zeroAndWe();
    t_loadUse();
    t_noStall();
    t_taken();
    t_sweep();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule